// File: doc/BRIEF.md
# First-Order Recursive Filter with Sample Hold

This block is a fixed-point first-order recursive (IIR) filter. On each cycle where its sample enable is high, it takes a new signed input sample. It forms a weighted sum of three terms: that sample, the previous accepted sample and the previous output. It then rounds and saturates the sum and registers it as the new output. On every other cycle the input is ignored and the last output is held. The block therefore works as a filter running at a reduced rate selected by the enable, and its output is stretched back to the full clock rate.

The three weights are build-time parameters in a signed format with `FRAC_W` fraction bits (Q1.14 for 16-bit coefficients). The first accepted sample after reset is special: it produces only the weighted current input, because no past input or output exists yet. A valid flag marks when the output carries a computed value.

Top module: `iir1_hold_filter`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, and until the first enabled cycle afterwards, `y_out` is 0 and `y_vld` is 0.
- R2: The first enabled cycle after reset yields `y_out = round(A0*x)`, with no term from earlier inputs or outputs.
- R3: Every later enabled cycle yields `y_out = round(A0*x[n] + A1*x[n-1] - B1*y[n-1])`. Here `x[n-1]` and `y[n-1]` are the input and output of the previous enabled cycle.
- R4: On a cycle with `smp_en` low, `x_in` is ignored: `y_out`, `y_vld` and the stored past input do not change.
- R5: `y_vld` goes to 1 on the first enabled cycle after reset and stays at 1 until the next reset.
- R6: Rounding adds half an output LSB (2^(FRAC_W-1) in product units) to the full-width sum, then shifts right arithmetically by FRAC_W. Ties therefore round towards plus infinity: 1.5 becomes 2 and -1.5 becomes -1.
- R7: A rounded result above 32767 gives 32767, and one below -32768 gives -32768. The value saturated in this way is also the value fed back as y[n-1].
- R8: The output register changes only at the clock edge that samples `smp_en` high. Between that edge and the one before it, `y_out` still shows the previous result.
- R9: A reset in the middle of a run clears the past terms, so the next enabled cycle follows the first-sample rule again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable; the filter advances only when high |
| x_in | input | DATA_W | Signed input sample |
| y_out | output | DATA_W | Signed filtered output, held between enabled cycles |
| y_vld | output | 1 | High once a result has been computed since reset |

## Verification
The bench sweeps the whole input range in fixed strides under an irregular enable pattern. It compares every cycle against a wide-integer model of the recurrence.

It targets four kinds of corner case:
- The first sample after reset and after a mid-run reset. A design that leaked stale past terms would be off by the A1 and B1 contributions.
- Exact half-LSB ties. These would show a design that truncated or rounded away from zero, because its results would differ by one.
- Sustained full-scale input. This drives the accumulator past the output range, where a design that wrapped instead of clamping would flip sign.
- Long disabled stretches with a changing input. A design that let the input leak into its state would differ on the next enabled cycle.

// File: rtl/iir1_pkg.sv
package iir1_pkg;

  // Whether past input/output terms take part in the current sum.
  typedef enum logic [0:0] {
    HIST_EMPTY = 1'b0,
    HIST_READY = 1'b1
  } hist_state_t;

  // Number of product taps in a first-order section.
  localparam int TAP_COUNT = 3;

endpackage

// File: rtl/iir1_tap.sv
module iir1_tap #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int COEF   = 0
) (
  input  logic signed [DATA_W-1:0]        op_i,
  input  logic                            use_i,
  output logic signed [DATA_W+COEF_W:0]   prod_o
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int K_W    = COEF_W + 1;
  localparam logic signed [K_W-1:0] K = K_W'(COEF);

  logic signed [PROD_W-1:0] op_ext;
  logic signed [PROD_W-1:0] k_ext;

  assign op_ext = PROD_W'(op_i);
  assign k_ext  = PROD_W'(K);

  always_comb begin
    if (use_i) prod_o = op_ext * k_ext;
    else       prod_o = '0;
  end
endmodule

// File: rtl/iir1_round_sat.sv
module iir1_round_sat #(
  parameter int DATA_W = 16,
  parameter int PROD_W = 33,
  parameter int FRAC_W = 14,
  parameter int N_IN   = 3
) (
  input  logic signed [PROD_W-1:0] prod_i [N_IN],
  output logic signed [DATA_W-1:0] y_o
);
  localparam int ACC_W = PROD_W + $clog2(N_IN) + 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(1 << (DATA_W - 1)));

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rnd;
  logic signed [ACC_W-1:0] shf;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_IN; i++) acc = acc + ACC_W'(prod_i[i]);
  end

  assign rnd = acc + HALF;
  assign shf = rnd >>> FRAC_W;

  always_comb begin
    if (shf > MAXV)      y_o = MAXV[DATA_W-1:0];
    else if (shf < MINV) y_o = MINV[DATA_W-1:0];
    else                 y_o = shf[DATA_W-1:0];
  end
endmodule

// File: rtl/iir1_state.sv
module iir1_state
  import iir1_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_new_i,
  output logic signed [DATA_W-1:0] x_prev_o,
  output logic signed [DATA_W-1:0] y_prev_o,
  output hist_state_t              hist_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev_o <= '0;
      y_prev_o <= '0;
      hist_o   <= HIST_EMPTY;
    end else if (adv_i) begin
      x_prev_o <= x_i;
      y_prev_o <= y_new_i;
      hist_o   <= HIST_READY;
    end
  end

  // R4: nothing stored moves on a disabled cycle
  p_state_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(x_prev_o) && $stable(y_prev_o) && $stable(hist_o)));

  // R5: history, once present, persists until reset
  p_hist_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_o == HIST_READY) |=> (hist_o == HIST_READY));
endmodule

// File: rtl/iir1_hold_filter.sv
module iir1_hold_filter
  import iir1_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter int A0     = 12288,
  parameter int A1     = 8192,
  parameter int B1     = -4096
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_en,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [DATA_W-1:0] y_out,
  output logic                     y_vld
);
  localparam int PROD_W = DATA_W + COEF_W + 1;

  logic signed [DATA_W-1:0] x_prev;
  logic signed [DATA_W-1:0] y_prev;
  logic signed [DATA_W-1:0] y_next;
  hist_state_t              hist;
  logic                     use_past;

  logic signed [DATA_W-1:0] tap_op  [TAP_COUNT];
  logic                     tap_use [TAP_COUNT];
  logic signed [PROD_W-1:0] tap_prod[TAP_COUNT];

  assign use_past   = (hist == HIST_READY);
  assign tap_op[0]  = x_in;
  assign tap_use[0] = 1'b1;
  assign tap_op[1]  = x_prev;
  assign tap_use[1] = use_past;
  assign tap_op[2]  = y_prev;
  assign tap_use[2] = use_past;

  for (genvar g = 0; g < TAP_COUNT; g++) begin : g_tap
    localparam int KC = (g == 0) ? A0 : ((g == 1) ? A1 : -B1);
    iir1_tap #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .COEF  (KC)
    ) u_tap (
      .op_i  (tap_op[g]),
      .use_i (tap_use[g]),
      .prod_o(tap_prod[g])
    );
  end

  iir1_round_sat #(
    .DATA_W(DATA_W),
    .PROD_W(PROD_W),
    .FRAC_W(FRAC_W),
    .N_IN  (TAP_COUNT)
  ) u_rs (
    .prod_i(tap_prod),
    .y_o   (y_next)
  );

  iir1_state #(
    .DATA_W(DATA_W)
  ) u_state (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (smp_en),
    .x_i     (x_in),
    .y_new_i (y_next),
    .x_prev_o(x_prev),
    .y_prev_o(y_prev),
    .hist_o  (hist)
  );

  assign y_out = y_prev;
  assign y_vld = use_past;

  // R1: no computed value yet means a zero output
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !y_vld |-> (y_out == '0));

  // R5: an enabled cycle while not yet valid makes the output valid
  p_first_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !y_vld) |=> y_vld);

  // R4 / R8: output holds across a disabled cycle
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(y_out));
endmodule

// File: tb/iir1_hold_filter_tb_top.sv
module iir1_hold_filter_tb_top;
  localparam int A0 = 12288;
  localparam int A1 = 8192;
  localparam int B1 = -4096;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_en = 1'b0;
  logic signed [15:0] x_in = '0;
  logic signed [15:0] y_out;
  logic               y_vld;

  int n_chk = 0;
  int n_bad = 0;

  longint m_xp = 0, m_yp = 0;
  bit     m_prim = 0;
  bit [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  iir1_hold_filter #(.DATA_W(16), .COEF_W(16), .FRAC_W(14),
                     .A0(A0), .A1(A1), .B1(B1)) dut_i (
    .clk(clk), .rst(rst), .smp_en(smp_en),
    .x_in(x_in), .y_out(y_out), .y_vld(y_vld));

  function automatic bit [31:0] nxt(input bit [31:0] s);
    bit [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model: returns expected output, sets sat flag
  function automatic longint model(input longint xv, output bit sat);
    longint acc, q;
    acc = A0 * xv;
    if (m_prim) acc = acc + A1 * m_xp - B1 * m_yp;
    q = (acc + 8192) >>> 14;
    sat = 0;
    if (q > 32767)  begin q = 32767;  sat = 1; end
    if (q < -32768) begin q = -32768; sat = 1; end
    return q;
  endfunction

  task automatic step(input int xv, input bit ev, input string force_tag);
    longint e; bit sat; string tag;
    @(negedge clk);
    rst = 1'b0; smp_en = ev; x_in = 16'(xv);
    #2;
    chk("R8", y_out, m_prim ? m_yp : 0);
    if (ev) begin
      e = model(xv, sat);
      tag = !m_prim ? "R2" : (sat ? "R7" : "R3");
    end else begin
      e = m_prim ? m_yp : 0;
      tag = "R4";
    end
    if (force_tag != "") tag = force_tag;
    @(posedge clk); #1;
    if (ev) begin m_xp = xv; m_yp = e; m_prim = 1; end
    chk(tag, y_out, e);
    chk(ev ? "R5" : "R4", y_vld, m_prim);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; smp_en = 1'b1; x_in = 16'sd12345;
    repeat (2) @(posedge clk);
    #1;
    m_xp = 0; m_yp = 0; m_prim = 0;
    chk(tag, y_out, 0);
    chk(tag, y_vld, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", y_out, 0);
    chk("R1", y_vld, 0);
    // disabled before any sample: still idle
    for (int i = 0; i < 4; i++) step(i * 9001 - 15000, 0, "R1");
    step(1000, 1, "R2");
    step(-500, 1, "R3");
    for (int i = 0; i < 6; i++) step(30000 - i * 7000, 0, "R4");
    step(200, 1, "R3");
    // rounding ties: 0.75*2=1.5 -> 2, 0.75*-2=-1.5 -> -1
    do_reset("R9");
    step(2, 1, "R6");
    do_reset("R9");
    step(-2, 1, "R6");
    do_reset("R9");
    step(-1, 1, "R6");
    // saturation both ways
    for (int i = 0; i < 8; i++) step(32767, 1, "");
    for (int i = 0; i < 12; i++) step(-32768, 1, "");
    do_reset("R9");
    step(-7777, 1, "R2");
    // stride sweep over whole input range with irregular enable
    for (int i = 0; i < 676; i++) begin
      seed = nxt(seed);
      step(-32768 + i * 97, seed[3:0] != 4'd0 && seed[5:4] != 2'd0, "");
    end
    // pseudo-random phase with mid-run resets
    for (int i = 0; i < 4000; i++) begin
      seed = nxt(seed);
      if (seed[11:0] == 12'd7) do_reset("R9");
      step($signed(seed[31:16]), seed[2:0] != 3'd0, "");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule